// File: doc/BRIEF.md
# Multi-Channel Interrupt Control and Status Register

This block holds one 32-bit interrupt control word per transfer channel. For each of five event kinds it keeps a per-channel enable, a sticky status flag and a write-one-to-clear field. The five kinds are fragment done, block done, transaction done, linked-list done and configuration error. The transfer engine raises single-cycle event pulses, and the block records those that are enabled. Each channel has an interrupt line, and the block gathers all of these lines into one readable vector with one bit per channel.

Software writes the channel word to set the enables and to clear status. It reads the channel word to see which events fired. It reads the vector to find which channels are interrupting. Each channel also takes a two-bit completion mode. From that mode and its status flags the block reports whether the current request has reached its completion level. The levels rise from fragment, through block and transaction, up to list.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, every channel word reads 0, the vector reads 0, and all interrupt and done outputs are 0.
- R2: Bits 4:0 of a channel word are read/write enables, in this order from bit 0: fragment, block, transaction, list, config error.
- R3: A status flag at bits 20:16, in the same order, is set in the cycle after its event pulse only if the enable was already 1. An event whose enable is 0 leaves the flag at 0.
- R4: A set status flag stays set until it is cleared, whatever the later events or enable writes.
- R5: Writing 1 to bit 24+k of a channel word clears status flag k in the next cycle. Writing 0 there leaves it unchanged. Bits 28:24 and all unused bits always read as 0.
- R6: When an enabled event and a clear of the same flag occur in one cycle, the flag ends up set.
- R7: A channel's interrupt output is 1 exactly when any of its five status flags is set.
- R8: The word of channel c sits at byte address 0x1000 + 0x40*c + 0xC, and the channel vector sits at byte address 0x14. Any other address reads 0, and writes to it change nothing.
- R9: With completion mode m (0 to 3), the channel's done output is 1 when a status flag of level index m or higher is set, counting fragment=0, block=1, transaction=2, list=3. The config-error flag never drives done.
- R10: The summary interrupt output is the OR of all channel interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | ADDR_W | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| evt | input | NUM_CH*5 | Event pulses, five per channel, channel c at bits 5c+4:5c |
| cmpl_mode | input | NUM_CH*2 | Completion mode per channel |
| ch_irq | output | NUM_CH | Per-channel interrupt lines |
| ch_done | output | NUM_CH | Per-channel completion reached |
| irq | output | 1 | OR of all channel interrupt lines |

## Verification
The hardest cases to reach are the ones where three things collide in one cycle: an enabled event, a write to the same channel word that clears that same flag, and a change of enables. The random stimulus drives sparse event pulses on every channel. Most of its writes go to real channel words, with random clear and enable fields, so these collisions happen often. Directed steps then force set-versus-clear collisions, events with the enable off, and each completion mode with only a single level set.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned EV_N    = 5;
  localparam int unsigned EN_LSB  = 0;
  localparam int unsigned STS_LSB = 16;
  localparam int unsigned CLR_LSB = 24;
  localparam int unsigned LVL_N   = 4;

  typedef enum logic [2:0] {
    EV_FRAG = 3'd0,
    EV_BLK  = 3'd1,
    EV_TRSC = 3'd2,
    EV_LIST = 3'd3,
    EV_CERR = 3'd4
  } ev_kind_e;

  function automatic logic [31:0] pack_word(input logic [EV_N-1:0] en,
                                            input logic [EV_N-1:0] sts);
    logic [31:0] w;
    w = '0;
    w[EN_LSB +: EV_N]  = en;
    w[STS_LSB +: EV_N] = sts;
    return w;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_addr_dec.sv
module irq_addr_dec #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned CH_BASE     = 32'h1000,
  parameter int unsigned CH_STRIDE   = 32'h40,
  parameter int unsigned CH_WORD_OFF = 32'hC,
  parameter int unsigned VEC_OFF     = 32'h14
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] ch_hit,
  output logic              vec_hit
);
  localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(VEC_OFF);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(CH_BASE + c*CH_STRIDE + CH_WORD_OFF);
    assign ch_hit[c] = (addr == WADDR);
  end

  assign vec_hit = (addr == VEC_ADDR);
endmodule

// File: rtl/irq_chan_reg.sv
module irq_chan_reg
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [31:0]      wdata,
  input  logic [EV_N-1:0]  evt,
  input  logic [1:0]       mode,
  output logic [EV_N-1:0]  en,
  output logic [EV_N-1:0]  sts,
  output logic             irq_line,
  output logic             done,
  output logic [31:0]      word
);
  logic [EV_N-1:0]  en_q, en_d, sts_q, sts_d, clr, hit_set;
  logic [LVL_N-1:0] lvl_mask;
  logic             upd;

  always_comb begin
    hit_set = evt & en_q;
    clr     = wr_hit ? wdata[CLR_LSB +: EV_N] : '0;
    en_d    = wr_hit ? wdata[EN_LSB +: EV_N] : en_q;
    sts_d   = (sts_q & ~clr) | hit_set;
    upd     = wr_hit | (|hit_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sts_q <= '0;
    end else if (upd) begin
      en_q  <= en_d;
      sts_q <= sts_d;
    end
  end

  always_comb begin
    lvl_mask = {LVL_N{1'b1}} << mode;
    done     = |(sts_q[LVL_N-1:0] & lvl_mask);
  end

  assign en       = en_q;
  assign sts      = sts_q;
  assign irq_line = |sts_q;
  assign word     = pack_word(en_q, sts_q);
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [NUM_CH*5-1:0]  evt,
  input  logic [NUM_CH*2-1:0]  cmpl_mode,
  output logic [NUM_CH-1:0]    ch_irq,
  output logic [NUM_CH-1:0]    ch_done,
  output logic                 irq
);
  localparam int unsigned EVW = NUM_CH * EV_N;

  logic              rst_n_sync;
  logic [NUM_CH-1:0] ch_hit;
  logic              vec_hit;
  logic [EVW-1:0]    en_all, sts_all;
  logic [31:0]       ch_word [NUM_CH];

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  irq_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr    (addr),
    .ch_hit  (ch_hit),
    .vec_hit (vec_hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    irq_chan_reg u_chan (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .wr_hit   (wr_en & ch_hit[c]),
      .wdata    (wdata),
      .evt      (evt[c*EV_N +: EV_N]),
      .mode     (cmpl_mode[c*2 +: 2]),
      .en       (en_all[c*EV_N +: EV_N]),
      .sts      (sts_all[c*EV_N +: EV_N]),
      .irq_line (ch_irq[c]),
      .done     (ch_done[c]),
      .word     (ch_word[c])
    );
  end

  always_comb begin
    rdata = vec_hit ? 32'(ch_irq) : 32'd0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_hit[c]) rdata = rdata | ch_word[c];
    end
  end

  assign irq = |ch_irq;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [31:0]         wdata,
  input logic [NUM_CH*5-1:0] evt,
  input logic [NUM_CH*5-1:0] en_all,
  input logic [NUM_CH*5-1:0] sts_all,
  input logic [NUM_CH-1:0]   ch_irq,
  input logic [NUM_CH-1:0]   ch_done,
  input logic                irq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic wr_c;
    assign wr_c = wr_en && (addr == ADDR_W'(32'h1000 + c*32'h40 + 32'hC));

    p_done_needs_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ch_done[c] |-> ch_irq[c]);

    for (genvar k = 0; k < 5; k++) begin : g_k
      p_set_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_all[c*5+k]) |-> $past(evt[c*5+k] && en_all[c*5+k]));
      p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_all[c*5+k] && !(wr_c && wdata[24+k])) |=> sts_all[c*5+k]);
      p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && wdata[24+k] && !(evt[c*5+k] && en_all[c*5+k])) |=> !sts_all[c*5+k]);
      p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[c*5+k] && en_all[c*5+k]) |=> sts_all[c*5+k]);
    end
  end

  p_irq_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(evt & en_all)));
endmodule

bind irq_ctrl_top irq_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_sync),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .evt     (evt),
  .en_all  (en_all),
  .sts_all (sts_all),
  .ch_irq  (ch_irq),
  .ch_done (ch_done),
  .irq     (irq)
);

// File: tb/irq_ctrl_top_tb.sv
module irq_ctrl_top_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [AW-1:0]   addr;
  logic [31:0]     wdata;
  logic [31:0]     rdata;
  logic [NCH*5-1:0] evt;
  logic [NCH*2-1:0] cmpl_mode;
  logic [NCH-1:0]  ch_irq, ch_done;
  logic            irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [4:0] en_m  [NCH];
  logic [4:0] sts_m [NCH];

  always #2 clk = ~clk;

  irq_ctrl_top #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt(evt), .cmpl_mode(cmpl_mode), .ch_irq(ch_irq),
    .ch_done(ch_done), .irq(irq)
  );

  function automatic logic [AW-1:0] ch_addr(input int c);
    return AW'(32'h1000 + c*32'h40 + 32'hC);
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    logic [31:0] r;
    r = 32'd0;
    if (a == AW'(32'h14)) begin
      for (int c = 0; c < NCH; c++) r[c] = |sts_m[c];
    end
    for (int c = 0; c < NCH; c++)
      if (a == ch_addr(c)) r = {11'd0, sts_m[c], 11'd0, en_m[c]};
    return r;
  endfunction

  function automatic logic exp_done(input int c, input logic [1:0] m);
    logic d;
    d = 1'b0;
    for (int k = 0; k < 4; k++) if (k >= m && sts_m[c][k]) d = 1'b1;
    return d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic any;
    any = 1'b0;
    chk("R2/R3/R5/R8 rdata", rdata, exp_read(addr));
    for (int c = 0; c < NCH; c++) begin
      chk("R7 ch_irq", 32'(ch_irq[c]), 32'(|sts_m[c]));
      chk("R9 ch_done", 32'(ch_done[c]), 32'(exp_done(c, cmpl_mode[c*2 +: 2])));
      any |= |sts_m[c];
    end
    chk("R10 irq", 32'(irq), 32'(any));
  endtask

  task automatic step(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                      input logic [NCH*5-1:0] e);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; evt = e;
    #1;
    check_outputs();
    for (int c = 0; c < NCH; c++) begin
      logic [4:0] clr, nen;
      clr = 5'd0; nen = en_m[c];
      if (we && a == ch_addr(c)) begin clr = d[28:24]; nen = d[4:0]; end
      sts_m[c] = (sts_m[c] & ~clr) | (e[c*5 +: 5] & en_m[c]);
      en_m[c]  = nen;
    end
    @(posedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b0; addr = a; evt = '0;
    #1;
    v = rdata;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) begin en_m[c] = '0; sts_m[c] = '0; end
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; evt = '0; cmpl_mode = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      rd(ch_addr(c), v); chk("R1 channel word", v, 32'd0);
    end
    rd(AW'(16'h14), v); chk("R1 vector", v, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 done", 32'(ch_done), 32'd0);

    // R2 enable write readback, clear bits read 0 (R5)
    step(1'b1, ch_addr(1), 32'hFFFF_FFFF, '0);
    rd(ch_addr(1), v); chk("R2/R5 enable readback", v, 32'h0000_001F);

    // R3 event with enable off leaves flag clear
    step(1'b0, '0, '0, 20'(5'b11111) << 0);
    rd(ch_addr(0), v); chk("R3 disabled event ignored", v, 32'd0);
    chk("R7 no irq on ch0", 32'(ch_irq[0]), 32'd0);

    // R3 enabled fragment event on ch1 sets bit 16
    step(1'b0, '0, '0, 20'(5'b00001) << 5);
    rd(ch_addr(1), v); chk("R3 fragment flag", v, 32'h0001_001F);

    // R4 sticky through idle and enable write of 0
    step(1'b1, ch_addr(1), 32'h0000_0000, '0);
    repeat (3) step(1'b0, '0, '0, '0);
    rd(ch_addr(1), v); chk("R4 sticky", v, 32'h0001_0000);

    // R9 modes with only fragment set: done only for mode 0
    cmpl_mode = 8'b00_00_00_00; #1; chk("R9 mode0 fragment", 32'(ch_done[1]), 32'd1);
    cmpl_mode = 8'b00_00_01_00; #1; chk("R9 mode1 fragment", 32'(ch_done[1]), 32'd0);
    cmpl_mode = 8'b00_00_11_00; #1; chk("R9 mode3 fragment", 32'(ch_done[1]), 32'd0);

    // R5 clear
    step(1'b1, ch_addr(1), 32'h0100_0000, '0);
    rd(ch_addr(1), v); chk("R5 clear", v, 32'd0);

    // R9 config error alone never gives done; R7 irq still set
    step(1'b1, ch_addr(2), 32'h0000_0010, '0);
    step(1'b0, '0, '0, 20'(5'b10000) << 10);
    cmpl_mode = 8'b00_00_00_00; #1;
    chk("R9 cfg error no done", 32'(ch_done[2]), 32'd0);
    chk("R7 cfg error irq", 32'(ch_irq[2]), 32'd1);
    rd(AW'(16'h14), v); chk("R8 vector bit", v, 32'h0000_0004);

    // R6 set wins over clear in same cycle
    step(1'b1, ch_addr(3), 32'h0000_0004, '0);
    step(1'b1, ch_addr(3), 32'h1F00_0004, 20'(5'b00100) << 15);
    rd(ch_addr(3), v); chk("R6 set beats clear", v, 32'h0004_0004);
    cmpl_mode = 8'b10_00_00_00; #1; chk("R9 mode2 transaction", 32'(ch_done[3]), 32'd1);

    // R8 unmapped writes ignored
    step(1'b1, AW'(16'h1008), 32'hFFFF_FFFF, '0);
    step(1'b1, AW'(16'h0014), 32'hFFFF_FFFF, '0);
    rd(ch_addr(0), v); chk("R8 unmapped write ignored", v, 32'd0);
    rd(AW'(16'h1008), v); chk("R8 unmapped read zero", v, 32'd0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      logic [NCH*5-1:0] e;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 7)       a = ch_addr(int'($urandom_range(0, NCH-1)));
      else if (sel == 7) a = AW'(16'h14);
      else               a = AW'($urandom_range(0, 16'h1200));
      for (int b = 0; b < NCH*5; b++) e[b] = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 15) == 0) cmpl_mode = NCH*2'($urandom);
      step($urandom_range(0, 2) == 0, a, $urandom, e);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule